// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Sine Synthesizer

This block is a direct digital synthesis core that produces two sine sample streams, A and B, at one shared programmable frequency. B lags or leads A by a programmable phase offset. One 20-bit phase accumulator drives both channels. Channel A reads the sine table at the top accumulator bits. Channel B reads it at the same address plus an 8-bit phase code, so the two channels can never drift apart in frequency.

Frequency, phase offset and amplitude are presets. They are captured, after range limiting, on a load strobe, and they are also driven out for an external decimal display. A sample-rate enable is pulsed at 2^20 Hz, so one frequency LSB is exactly 1 Hz. A small controller holds the generator in `ST_IDLE` (outputs at mid-scale, accumulator frozen) from reset until the first load. The transition *first load* moves it to `ST_RUN`, and the transition *hold* keeps it there; later loads only update the presets. An optional multiplier scales both channels by the amplitude code in steps of 1/30 of full scale.

Top module: `dds_dual_gen`

## Requirements
- R1: During and right after reset both outputs read 512, the shown presets read frequency 1, phase 0 and amplitude 30, and the controller is in `ST_IDLE`.
- R2: In `ST_IDLE` the sample enable has no effect: both outputs stay at 512 and the accumulator does not move. A load takes the controller to `ST_RUN` on the next edge, and it stays there until reset.
- R3: Presets are captured only on a clock edge with `load` high. Changing `freq_in`, `phase_in` or `amp_in` without a load changes neither the shown presets nor the output waveform.
- R4: A frequency code of 0 is stored as 1, a code above 4000 is stored as 4000, and codes from 1 to 4000 are stored unchanged.
- R5: The 20-bit accumulator adds the stored frequency once per enabled sample in `ST_RUN` and wraps modulo 2^20. A load never clears it.
- R6: The sine table at index k (0..1023) holds 512 + round(511·sin(2πk/1024)), with the rounding applied to the magnitude. Channel A's raw sample is the table entry at accumulator bits [19:10].
- R7: Channel B reads the table at (accumulator bits [19:10] + 4·phase code) mod 1024, so one code step is 360/256 degrees. With phase code 0, A and B are identical.
- R8: Each output equals ((raw − 512)·c)/30 + 512, with the division truncating toward zero and c the stored amplitude code. An amplitude code of 0 is stored as 1 and a code of 31 is stored as 30.
- R9: The outputs change only on a clock edge with the sample enable high in `ST_RUN`. At that edge they take the values computed from the accumulator as it was before that edge's increment, and A and B update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample-rate strobe, one cycle per output sample |
| load | input | 1 | Captures the three preset inputs |
| freq_in | input | 12 | Frequency code, 1 Hz per LSB |
| phase_in | input | 8 | Phase offset of B, 360/256 degrees per LSB |
| amp_in | input | 5 | Amplitude code, 1/30 of full scale per LSB |
| out_a | output | 10 | Channel A sample, offset binary |
| out_b | output | 10 | Channel B sample, offset binary |
| freq_shown | output | 12 | Stored frequency preset |
| phase_shown | output | 8 | Stored phase preset |
| amp_shown | output | 5 | Stored amplitude preset |

## Verification
The bench builds the block with its default parameters: a 20-bit accumulator, a 1024-entry 10-bit table, 8-bit phase and 5-bit amplitude codes, and the scaler present. At the 4000 Hz limit with an enable on every cycle, the accumulator wraps within about 263 cycles, so wrap-around and a load in the middle of a run both fall inside a short test. Phase codes 0, 64, 128 and 255 and amplitude codes 1, 15 and 30 cover the identical, quadrature, inverted and near-full-circle relations, as well as the truncating division on both sides of mid-scale.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dds_state_e;

    function automatic int clamp_range(input int v, input int lo, input int hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

    // Table entry: mid + round(peak * |sin|), sign from the half-wave.
    function automatic int sine_code(input int idx, input int depth, input int peak);
        int  qtr;
        int  quad;
        int  k;
        real x;
        real term;
        real sum;
        int  mag;
        qtr  = depth / 4;
        quad = idx / qtr;
        k    = idx % qtr;
        if (quad % 2 == 1) k = qtr - k;
        x    = 1.5707963267948966 * real'(k) / real'(qtr);
        term = x;
        sum  = x;
        for (int n = 1; n < 9; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        mag = $rtoi(real'(peak) * sum + 0.5);
        if (quad >= 2) return (peak + 1) - mag;
        else           return (peak + 1) + mag;
    endfunction

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
    import dds_pkg::*;
#(
    parameter int FREQ_W    = 12,
    parameter int PH_W      = 8,
    parameter int AMP_W     = 5,
    parameter int FREQ_MAX  = 4000,
    parameter int AMP_STEPS = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic [PH_W-1:0]   phase_in,
    input  logic [AMP_W-1:0]  amp_in,
    output logic [FREQ_W-1:0] freq_q,
    output logic [PH_W-1:0]   phase_q,
    output logic [AMP_W-1:0]  amp_q,
    output logic              running
);

    dds_state_e state_q;
    dds_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q  <= FREQ_W'(1);
            phase_q <= '0;
            amp_q   <= AMP_W'(AMP_STEPS);
        end else if (load) begin
            freq_q  <= FREQ_W'(clamp_range(int'(freq_in), 1, FREQ_MAX));
            phase_q <= phase_in;
            amp_q   <= AMP_W'(clamp_range(int'(amp_in), 1, AMP_STEPS));
        end
    end

endmodule

// File: rtl/dds_phase.sv
module dds_phase #(
    parameter int ACC_W  = 20,
    parameter int LUT_AW = 10,
    parameter int FREQ_W = 12,
    parameter int PH_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [FREQ_W-1:0] freq,
    input  logic [PH_W-1:0]   phase,
    output logic [LUT_AW-1:0] addr_a,
    output logic [LUT_AW-1:0] addr_b
);

    localparam int PH_SHIFT = LUT_AW - PH_W;

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (advance) acc_q <= acc_q + ACC_W'(freq);
    end

    always_comb begin
        addr_a = acc_q[ACC_W-1 -: LUT_AW];
        addr_b = addr_a + (LUT_AW'(phase) << PH_SHIFT);
    end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 10
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    localparam int DEPTH = 1 << AW;
    localparam int PEAK  = (1 << (DW - 1)) - 1;

    logic [DW-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = DW'(sine_code(i, DEPTH, PEAK));
    end

    assign data = table_q[addr];

endmodule

// File: rtl/dds_amp.sv
module dds_amp #(
    parameter int SMP_W     = 10,
    parameter int AMP_W     = 5,
    parameter int AMP_STEPS = 30
) (
    input  logic [SMP_W-1:0] raw,
    input  logic [AMP_W-1:0] gain,
    output logic [SMP_W-1:0] scaled
);

    localparam int MID = 1 << (SMP_W - 1);

    int centred;
    int product;

    always_comb begin
        centred = int'(raw) - MID;
        product = (centred * int'(gain)) / AMP_STEPS;
        scaled  = SMP_W'(product + MID);
    end

endmodule

// File: rtl/dds_dual_gen.sv
module dds_dual_gen #(
    parameter int ACC_W     = 20,
    parameter int LUT_AW    = 10,
    parameter int SMP_W     = 10,
    parameter int FREQ_W    = 12,
    parameter int PH_W      = 8,
    parameter int AMP_W     = 5,
    parameter int FREQ_MAX  = 4000,
    parameter int AMP_STEPS = 30,
    parameter bit AMP_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              load,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic [PH_W-1:0]   phase_in,
    input  logic [AMP_W-1:0]  amp_in,
    output logic [SMP_W-1:0]  out_a,
    output logic [SMP_W-1:0]  out_b,
    output logic [FREQ_W-1:0] freq_shown,
    output logic [PH_W-1:0]   phase_shown,
    output logic [AMP_W-1:0]  amp_shown
);

    localparam int N_CH = 2;
    localparam int MID  = 1 << (SMP_W - 1);

    logic              running;
    logic              step;
    logic [LUT_AW-1:0] addr  [N_CH];
    logic [SMP_W-1:0]  raw   [N_CH];
    logic [SMP_W-1:0]  shape [N_CH];
    logic [SMP_W-1:0]  smp_q [N_CH];

    assign step = sample_en & running;

    dds_ctrl #(
        .FREQ_W(FREQ_W), .PH_W(PH_W), .AMP_W(AMP_W),
        .FREQ_MAX(FREQ_MAX), .AMP_STEPS(AMP_STEPS)
    ) u_ctrl (
        .clk(clk), .rst(rst), .load(load),
        .freq_in(freq_in), .phase_in(phase_in), .amp_in(amp_in),
        .freq_q(freq_shown), .phase_q(phase_shown), .amp_q(amp_shown),
        .running(running)
    );

    dds_phase #(
        .ACC_W(ACC_W), .LUT_AW(LUT_AW), .FREQ_W(FREQ_W), .PH_W(PH_W)
    ) u_phase (
        .clk(clk), .rst(rst), .advance(step),
        .freq(freq_shown), .phase(phase_shown),
        .addr_a(addr[0]), .addr_b(addr[1])
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        dds_sine_rom #(.AW(LUT_AW), .DW(SMP_W)) u_rom (
            .addr(addr[ch]), .data(raw[ch])
        );

        if (AMP_EN) begin : g_scale
            dds_amp #(.SMP_W(SMP_W), .AMP_W(AMP_W), .AMP_STEPS(AMP_STEPS)) u_amp (
                .raw(raw[ch]), .gain(amp_shown), .scaled(shape[ch])
            );
        end else begin : g_bypass
            assign shape[ch] = raw[ch];
        end

        always_ff @(posedge clk) begin
            if (rst)       smp_q[ch] <= SMP_W'(MID);
            else if (step) smp_q[ch] <= shape[ch];
        end
    end

    assign out_a = smp_q[0];
    assign out_b = smp_q[1];

endmodule

// File: rtl/dds_dual_gen_chk.sv
module dds_dual_gen_chk #(
    parameter int SMP_W     = 10,
    parameter int FREQ_W    = 12,
    parameter int PH_W      = 8,
    parameter int AMP_W     = 5,
    parameter int FREQ_MAX  = 4000,
    parameter int AMP_STEPS = 30
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_en,
    input logic              load,
    input logic              running,
    input logic [SMP_W-1:0]  out_a,
    input logic [SMP_W-1:0]  out_b,
    input logic [FREQ_W-1:0] freq_shown,
    input logic [PH_W-1:0]   phase_shown,
    input logic [AMP_W-1:0]  amp_shown
);

    localparam int MID = 1 << (SMP_W - 1);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_en && running) |=> $stable(out_a) && $stable(out_b));

    // R3
    preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(freq_shown) && $stable(phase_shown) && $stable(amp_shown));

    // R4
    freq_range_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (int'(freq_shown) >= 1) && (int'(freq_shown) <= FREQ_MAX));

    // R8
    amp_range_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (int'(amp_shown) >= 1) && (int'(amp_shown) <= AMP_STEPS));

    // R2
    idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> (int'(out_a) == MID) && (int'(out_b) == MID));

    // R2
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> running);

    // R7
    zero_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && running && phase_shown == '0) |=> out_a == out_b);

endmodule

bind dds_dual_gen dds_dual_gen_chk #(
    .SMP_W(SMP_W), .FREQ_W(FREQ_W), .PH_W(PH_W), .AMP_W(AMP_W),
    .FREQ_MAX(FREQ_MAX), .AMP_STEPS(AMP_STEPS)
) u_chk (
    .clk(clk), .rst(rst), .sample_en(sample_en), .load(load),
    .running(running), .out_a(out_a), .out_b(out_b),
    .freq_shown(freq_shown), .phase_shown(phase_shown), .amp_shown(amp_shown)
);

// File: tb/sim_dds_dual_gen.sv
module sim_dds_dual_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_en = 1'b0;
    logic        load = 1'b0;
    logic [11:0] freq_in = '0;
    logic [7:0]  phase_in = '0;
    logic [4:0]  amp_in = '0;
    logic [9:0]  out_a;
    logic [9:0]  out_b;
    logic [11:0] freq_shown;
    logic [7:0]  phase_shown;
    logic [4:0]  amp_shown;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int m_acc, m_f, m_p, m_a, m_ea, m_eb;
    bit m_run;

    dds_dual_gen u0 (
        .clk(clk), .rst(rst), .sample_en(sample_en), .load(load),
        .freq_in(freq_in), .phase_in(phase_in), .amp_in(amp_in),
        .out_a(out_a), .out_b(out_b),
        .freq_shown(freq_shown), .phase_shown(phase_shown), .amp_shown(amp_shown)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic int lim(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int ref_sine(input int k);
        real s;
        int  m;
        s = $sin(2.0 * 3.14159265358979 * real'(k) / 1024.0);
        m = $rtoi(511.0 * ((s < 0.0) ? -s : s) + 0.5);
        return (s < 0.0) ? 512 - m : 512 + m;
    endfunction

    function automatic int ref_scale(input int s, input int c);
        return ((s - 512) * c) / 30 + 512;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp, input int tol);
        n_cmp++;
        if (absd(act, exp) > tol) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_f = 1; m_p = 0; m_a = 30; m_run = 1'b0;
            m_ea = 512; m_eb = 512;
        end else begin
            if (sample_en && m_run) begin
                int idx;
                idx  = m_acc / 1024;
                m_ea = ref_scale(ref_sine(idx), m_a);
                m_eb = ref_scale(ref_sine((idx + 4 * m_p) % 1024), m_a);
                m_acc = (m_acc + m_f) % (1 << 20);
            end
            if (load) begin
                m_f = lim(int'(freq_in), 1, 4000);
                m_p = int'(phase_in);
                m_a = lim(int'(amp_in), 1, 30);
                m_run = 1'b1;
            end
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, "out_a", int'(out_a), m_ea, 1);
            chk(cur_req, "out_b", int'(out_b), m_eb, 1);
            chk(cur_req, "freq_shown", int'(freq_shown), m_f, 0);
            chk(cur_req, "phase_shown", int'(phase_shown), m_p, 0);
            chk(cur_req, "amp_shown", int'(amp_shown), m_a, 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_load(input int f, input int p, input int a);
        @(negedge clk);
        freq_in = 12'(f); phase_in = 8'(p); amp_in = 5'(a); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic run_en(input int n, input int every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_en = (i % every == 0);
        end
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "out_a", int'(out_a), 512, 0);
        chk("R1", "out_b", int'(out_b), 512, 0);
        chk("R1", "freq_shown", int'(freq_shown), 1, 0);
        chk("R1", "phase_shown", int'(phase_shown), 0, 0);
        chk("R1", "amp_shown", int'(amp_shown), 30, 0);
        rst = 1'b0;

        // R2: enable ignored before the first load
        cur_req = "R2";
        run_en(12, 1);
        chk("R2", "idle out_a", int'(out_a), 512, 0);

        // R6 R7 R9: quadrature, enable every cycle
        cur_req = "R6";
        do_load(1000, 64, 30);
        run_en(300, 1);

        // R3: inputs change without load
        cur_req = "R3";
        freq_in = 12'd7; phase_in = 8'd9; amp_in = 5'd3;
        run_en(60, 1);
        chk("R3", "freq_shown held", int'(freq_shown), 1000, 0);
        chk("R3", "phase_shown held", int'(phase_shown), 64, 0);

        // R4 R8 R7: low clamps, identical channels
        cur_req = "R4";
        do_load(0, 0, 0);
        chk("R4", "freq 0 clamp", int'(freq_shown), 1, 0);
        chk("R8", "amp 0 clamp", int'(amp_shown), 1, 0);
        run_en(40, 1);
        chk("R7", "zero offset a==b", int'(out_a), int'(out_b), 0);

        // R4 R8 R9: high clamps, sparse enable, near-full-circle offset
        cur_req = "R9";
        do_load(4095, 255, 31);
        chk("R4", "freq high clamp", int'(freq_shown), 4000, 0);
        chk("R8", "amp 31 clamp", int'(amp_shown), 30, 0);
        run_en(300, 3);

        // R8 R7: half amplitude, inverted channel, load while enabled
        cur_req = "R8";
        sample_en = 1'b1;
        do_load(2500, 128, 15);
        run_en(200, 1);

        // R5: wrap at the limit frequency, reload mid-run
        cur_req = "R5";
        do_load(4000, 32, 30);
        run_en(400, 1);
        do_load(333, 200, 22);
        run_en(150, 2);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule